// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is an up-counting timer with three compare channels, set up and read through a small word-addressed register port. A three-bit source field in the control register chooses one of two tick-enable inputs: a fast peripheral tick or a slow 32 kHz tick. A code outside the valid set chooses no source, and the counter then stops. A prescaler divides the chosen tick, so the counter steps once for every prescaler-value-plus-one source ticks, and only while the enable bit is set.

Each compare channel, and a rollover event in free-running mode, sets its own sticky flag in a status register. Writing a one to a status bit clears that bit. The single level interrupt output is high while the enabled flags are nonzero and the timer is enabled. In restart mode, compare 1 sets the period. The counter goes back to zero on the step after it matches compare 1, and any write to compare 1 restarts the count. Setting the enable bit while enable-mode is set also restarts the count from zero. A software-reset bit in the control register returns the other registers to their reset values, clears the enable and low-power bits of the written control value, and keeps the rest of that value. The counter and compare width is the parameter CNT_W, 32 by default. Register reads are zero-extended to 32 bits.

Top module: `gp_timer`

## Requirements
- R1: Word offsets: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, 9 counter. The capture offsets always read zero. Offsets 10 and above read zero, and writes to them or to the capture offsets change nothing.
- R2: Control bits 8:6 select the source: 001 or 010 selects tick_fast, 100 selects tick_slow, and any other code selects no tick, so the counter holds.
- R3: The prescaler register keeps only write bits 11:0. While control bit 0 (enable) is set, the counter advances once per (prescaler+1) selected ticks.
- R4: Status bits 5:0 are set by events and cleared by writing ones to them. An event in the same cycle as the clearing write wins. The interrupt-enable register keeps write bits 5:0.
- R5: irq is high exactly when (status AND enable) is nonzero and control bit 0 is set.
- R6: After rst_n is low at a clock edge, control, prescaler, status, enable and counter read 0, and each compare register reads all ones.
- R7: A control write stores the written value with bits 2, 4, 10-14 and 15 forced to 0. If bit 15 of the write is set, bits 5:0 are also cleared, and status, prescaler, enable, counter and compares return to their R6 values.
- R8: A control write that takes bit 0 from 0 to 1 with bit 1 (enable-mode) set zeroes the counter. With bit 1 clear, the counter keeps its value.
- R9: With control bit 9 (free-run) clear, a write to compare 1 zeroes the counter. Writes to compare 2 or 3 never change the counter.
- R10: A step that makes the counter equal to compare 1, 2 or 3 sets status bit 0, 1 or 2.
- R11: With free-run clear, a step taken while the counter equals compare 1 loads zero instead of incrementing.
- R12: With free-run set, a step from all ones to zero sets status bit 5. Status bits 3 and 4 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_fast | input | 1 | Fast peripheral tick enable |
| tick_slow | input | 1 | Slow 32 kHz tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The counter is driven with an every-cycle tick, a random tick and a sparse slow tick, at more than one prescaler value. This separates a wrong division ratio from a wrong source decode, and an invalid source code shows that counting stops. Free-running and restart modes are each run across compare matches, which tells an off-by-one reload apart from a correct period. A run through the full counter range exposes rollover flagging. Enable transitions with and without enable-mode, compare writes in restart mode, and a software reset issued with the enable bit set each show whether the counter is zeroed or kept.

// File: rtl/tmr_pkg.sv
// Shared constants for the compare timer: register offsets, control bit
// positions, status flag positions and source codes.
// Assumes a 32-bit register port and exactly three compare channels.
package tmr_pkg;
    localparam int REG_W   = 32;
    localparam int NUM_CMP = 3;
    localparam int FLAG_W  = 6;

    localparam int OFS_CTRL = 0;
    localparam int OFS_PRE  = 1;
    localparam int OFS_STS  = 2;
    localparam int OFS_IEN  = 3;
    localparam int OFS_CMP0 = 4;
    localparam int OFS_CNT  = 9;

    localparam int CTRL_EN      = 0;
    localparam int CTRL_ENMOD   = 1;
    localparam int CTRL_SRC_LSB = 6;
    localparam int CTRL_FRR     = 9;
    localparam int CTRL_SWR     = 15;

    localparam logic [REG_W-1:0] CTRL_FORCE0 = 32'h0000_7C14;
    localparam logic [REG_W-1:0] CTRL_LOWPWR = 32'h0000_003F;

    localparam int FLG_ROV = 5;

    localparam logic [2:0] SRC_FAST_A = 3'b001;
    localparam logic [2:0] SRC_FAST_B = 3'b010;
    localparam logic [2:0] SRC_SLOW   = 3'b100;
endpackage

// File: rtl/tmr_prescale.sv
// Source selection and prescale divider.
// Picks one tick-enable input from the source code, then emits one step for
// every (div+1) selected ticks while run is high. clear restarts the division.
// Assumes the tick inputs are synchronous enables in the clk domain.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic [2:0]       src_sel,
    input  logic             run,
    input  logic [PRE_W-1:0] div,
    input  logic             clear,
    output logic             step
);
    logic [PRE_W-1:0] acc;
    logic             src_tick;
    logic             src_ok;

    // Decode the source code into the selected tick.
    always_comb begin
        src_tick = 1'b0;
        src_ok   = 1'b1;
        case (src_sel)
            SRC_FAST_A, SRC_FAST_B: src_tick = tick_fast;
            SRC_SLOW:               src_tick = tick_slow;
            default:                src_ok   = 1'b0;
        endcase
    end

    // A step fires on the tick that completes a division period.
    assign step = run & src_tick & (acc >= div);

    // Division accumulator: counts selected ticks, wraps on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc <= '0;
        end else if (run && src_tick) begin
            acc <= step ? '0 : acc + 1'b1;
        end
    end

    // R2: an invalid source code never produces a step.
    a_r2_no_source_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |-> !step);

    // R3: after an uncleared step the division starts again from zero.
    a_r3_step_restarts_div: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> (acc == '0));
endmodule

// File: rtl/tmr_core.sv
// Counter and compare match logic.
// Advances the counter on step. In restart mode, a step taken at compare 0
// reloads zero. Reports per-channel match events and the free-run rollover
// event for the step being taken. clear zeroes the counter and suppresses
// the events of that cycle.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    input  logic                            clear,
    input  logic                            free_run,
    input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp,
    output logic [CNT_W-1:0]                cnt,
    output logic [NUM_CMP-1:0]              cmp_hit,
    output logic                            rov_hit
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_next;
    logic             take;

    // Value the counter takes on a step.
    assign cnt_next = (!free_run && (cnt == cmp[0])) ? '0 : cnt + 1'b1;
    assign take     = step & ~clear;

    // One match detector per compare channel.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_hit
        assign cmp_hit[g] = take & (cnt_next == cmp[g]);
    end

    // Rollover is only flagged when free running.
    assign rov_hit = take & free_run & (cnt == CNT_TOP);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_next;
        end
    end

    // R11: restart mode reloads zero after a compare 0 match.
    a_r11_period_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !free_run && (cnt == cmp[0])) |=> (cnt == '0));

    // R8: a requested clear leaves the counter at zero.
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));

    // R10: a match event leaves the counter on that compare value.
    a_r10_hit_lands_on_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit[0] |=> (cnt == $past(cmp[0])));

    // R12: a rollover event leaves the counter at zero.
    a_r12_rollover_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        rov_hit |=> (cnt == '0));
endmodule

// File: rtl/gp_timer.sv
// Three-channel compare timer, top level.
// Holds the register file, decodes word-addressed writes, forms the counter
// clear requests and the sticky status, and drives the level interrupt.
// Assumes ADDR_W >= 4, CNT_W <= 32 and PRE_W <= 32. Reads are combinational.
module gp_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [REG_W-1:0]              ctrl_q;
    logic [PRE_W-1:0]              pre_q;
    logic [FLAG_W-1:0]             sts_q;
    logic [FLAG_W-1:0]             ien_q;
    logic [CNT_W-1:0]              cmp_q [NUM_CMP];
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_bus;
    logic [CNT_W-1:0]              cnt;
    logic [NUM_CMP-1:0]            cmp_hit;
    logic                          rov_hit;
    logic                          step;

    logic                          wr_ctrl, wr_pre, wr_sts, wr_ien;
    logic [NUM_CMP-1:0]            wr_cmp;
    logic                          soft_rst, en_restart, per_restart, cnt_clear;
    logic [REG_W-1:0]              ctrl_wval;
    logic [FLAG_W-1:0]             evt;
    logic [REG_W-1:0]              cnt_ext, pre_ext;
    logic [REG_W-1:0]              cmp_ext [NUM_CMP];

    // Write strobes for the fixed registers.
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_pre  = bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
    assign wr_sts  = bus_wr && (bus_addr == ADDR_W'(OFS_STS));
    assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));

    // Compare strobes, packing and read extension, one per channel.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        assign wr_cmp[g]  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP0 + g));
        assign cmp_bus[g] = cmp_q[g];
        always_comb begin
            cmp_ext[g] = '0;
            cmp_ext[g][CNT_W-1:0] = cmp_q[g];
        end
    end

    // Control write value with the always-zero bits removed.
    assign ctrl_wval   = bus_wdata & ~CTRL_FORCE0 & ~(REG_W'(1) << CTRL_SWR);
    assign soft_rst    = wr_ctrl && bus_wdata[CTRL_SWR];
    assign en_restart  = wr_ctrl && !soft_rst && !ctrl_q[CTRL_EN]
                         && bus_wdata[CTRL_EN] && bus_wdata[CTRL_ENMOD];
    assign per_restart = wr_cmp[0] && !ctrl_q[CTRL_FRR];
    assign cnt_clear   = soft_rst | en_restart | per_restart;

    // Control register: software reset drops the enable and low-power bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= soft_rst ? (ctrl_wval & ~CTRL_LOWPWR) : ctrl_wval;
        end
    end

    // Prescaler and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            pre_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_pre) pre_q <= bus_wdata[PRE_W-1:0];
            if (wr_ien) ien_q <= bus_wdata[FLAG_W-1:0];
        end
    end

    // Compare registers, reset to all ones.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CMP; i++) begin
            if (!rst_n || soft_rst) begin
                cmp_q[i] <= '1;
            end else if (wr_cmp[i]) begin
                cmp_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Event vector in status bit order; capture flags are never raised.
    always_comb begin
        evt = '0;
        evt[NUM_CMP-1:0] = cmp_hit;
        evt[FLG_ROV]     = rov_hit;
    end

    // Sticky status: write-one-to-clear, new events win.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (wr_sts ? (sts_q & ~bus_wdata[FLAG_W-1:0]) : sts_q) | evt;
        end
    end

    tmr_prescale #(.PRE_W(PRE_W)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .src_sel   (ctrl_q[CTRL_SRC_LSB +: 3]),
        .run       (ctrl_q[CTRL_EN]),
        .div       (pre_q),
        .clear     (cnt_clear),
        .step      (step)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .clear    (cnt_clear),
        .free_run (ctrl_q[CTRL_FRR]),
        .cmp      (cmp_bus),
        .cnt      (cnt),
        .cmp_hit  (cmp_hit),
        .rov_hit  (rov_hit)
    );

    // Zero-extend the narrow registers for reading.
    always_comb begin
        cnt_ext = '0;
        cnt_ext[CNT_W-1:0] = cnt;
        pre_ext = '0;
        pre_ext[PRE_W-1:0] = pre_q;
    end

    // Read multiplexer; capture and unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):     bus_rdata = ctrl_q;
            ADDR_W'(OFS_PRE):      bus_rdata = pre_ext;
            ADDR_W'(OFS_STS):      bus_rdata = REG_W'(sts_q);
            ADDR_W'(OFS_IEN):      bus_rdata = REG_W'(ien_q);
            ADDR_W'(OFS_CMP0):     bus_rdata = cmp_ext[0];
            ADDR_W'(OFS_CMP0 + 1): bus_rdata = cmp_ext[1];
            ADDR_W'(OFS_CMP0 + 2): bus_rdata = cmp_ext[2];
            ADDR_W'(OFS_CNT):      bus_rdata = cnt_ext;
            default:               bus_rdata = '0;
        endcase
    end

    // Level interrupt.
    assign irq = ctrl_q[CTRL_EN] & (|(sts_q & ien_q));

    // R4: clearing a flag with no event in that cycle leaves it clear.
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && bus_wdata[0] && !cmp_hit[0]) |=> !sts_q[0]);

    // R7: a software reset leaves the timer disabled and quiet.
    a_r7_swr_disables: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!ctrl_q[CTRL_EN] && !irq && (cnt == '0)));

    // R9: compare 2/3 writes do not disturb the counter.
    a_r9_cmp23_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_cmp[1] || wr_cmp[2]) && !step) |=> $stable(cnt));
endmodule

// File: tb/gp_timer_bench.sv
// Bench for gp_timer: a behavioural reference model is stepped on every
// clock and compared with the read port and irq, plus directed spot checks.
`timescale 1ns/1ps
module gp_timer_bench;
    localparam int CW = 12;
    localparam logic [CW-1:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;

    gp_timer #(.CNT_W(CW)) u_gp_timer (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 0;
    string phase = "R6 reset";
    int    fast_mode = 0;
    int    slow_cnt = 0;

    // Tick generators, driven away from the active edge.
    always @(negedge clk) begin
        slow_cnt  <= slow_cnt + 1;
        tick_slow <= (slow_cnt % 5 == 0);
        case (fast_mode)
            0: tick_fast <= 1'b1;
            1: tick_fast <= 1'($urandom % 2);
            default: tick_fast <= 1'b0;
        endcase
    end

    // Reference model state.
    logic [31:0]   m_cr, m_v;
    logic [11:0]   m_pr;
    logic [5:0]    m_sr, m_ie, m_ev, m_base;
    logic [CW-1:0] m_cmp [3];
    logic [CW-1:0] m_cnt, m_nx;
    int            m_pc;
    bit            m_t, m_stp, m_clr, m_swr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cr = 0; m_pr = 0; m_sr = 0; m_ie = 0; m_cnt = 0; m_pc = 0;
            for (int i = 0; i < 3; i++) m_cmp[i] = ONES;
        end else begin
            case (m_cr[8:6])
                3'd1, 3'd2: m_t = tick_fast;
                3'd4:       m_t = tick_slow;
                default:    m_t = 0;
            endcase
            m_stp = 0;
            if (m_cr[0] && m_t) begin
                if (m_pc >= int'(m_pr)) begin m_pc = 0; m_stp = 1; end
                else m_pc = m_pc + 1;
            end
            m_v   = bus_wdata & ~32'h0000_FC14;
            m_swr = bus_wr && bus_addr == 0 && bus_wdata[15];
            m_clr = m_swr
                 || (bus_wr && bus_addr == 0 && !m_cr[0] && bus_wdata[0] && bus_wdata[1])
                 || (bus_wr && bus_addr == 4 && !m_cr[9]);
            m_nx = (!m_cr[9] && m_cnt == m_cmp[0]) ? '0 : m_cnt + 1'b1;
            m_ev = 0;
            if (m_stp && !m_clr) begin
                for (int i = 0; i < 3; i++) m_ev[i] = (m_nx == m_cmp[i]);
                m_ev[5] = m_cr[9] && (m_cnt == ONES);
            end
            if (m_clr) begin m_cnt = 0; m_pc = 0; end
            else if (m_stp) m_cnt = m_nx;
            m_base = m_sr;
            if (bus_wr && bus_addr == 2) m_base = m_sr & ~bus_wdata[5:0];
            m_sr = m_base | m_ev;
            if (bus_wr) begin
                case (bus_addr)
                    0: m_cr = m_swr ? (m_v & ~32'h3F) : m_v;
                    1: m_pr = bus_wdata[11:0];
                    3: m_ie = bus_wdata[5:0];
                    4, 5, 6: m_cmp[bus_addr-4] = bus_wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (m_swr) begin
                m_sr = 0; m_pr = 0; m_ie = 0;
                for (int i = 0; i < 3; i++) m_cmp[i] = ONES;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            0: return m_cr;
            1: return {20'd0, m_pr};
            2: return {26'd0, m_sr};
            3: return {26'd0, m_ie};
            4, 5, 6: return {{(32-CW){1'b0}}, m_cmp[a-4]};
            9: return {{(32-CW){1'b0}}, m_cnt};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, after the edge settles.
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check({phase, " rdata"}, bus_rdata, m_read(bus_addr));
            check({phase, " R5 irq"}, {31'd0, irq},
                  {31'd0, (m_cr[0] && |(m_sr & m_ie))});
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd_now(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_addr = (i % 4 == 0) ? 4'd2 : 4'd9;
        end
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    logic [31:0] snap;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_now(0, 0, "R6 ctrl");
        rd_now(4, 32'hFFF, "R6 cmp1");
        rd_now(6, 32'hFFF, "R6 cmp3");
        rd_now(9, 0, "R6 counter");
        rd_now(2, 0, "R6 status");

        phase = "R1 map";
        wr(12, 32'hDEAD_BEEF);
        wr(7, 32'h55);
        rd_now(12, 0, "R1 unmapped");
        rd_now(7, 0, "R1 capture1");
        rd_now(8, 0, "R1 capture2");
        rd_now(0, 0, "R1 ctrl untouched");

        phase = "R3 prescaler width";
        wr(1, 32'hFFFF_F123);
        rd_now(1, 32'h123, "R3 prescaler low 12 bits");
        phase = "R4 enable width";
        wr(3, 32'hFF);
        rd_now(3, 32'h3F, "R4 enable low 6 bits");

        phase = "R7 ctrl mask";
        wr(0, 32'hFFFF_7FFE);
        rd_now(0, 32'hFFFF_03EA, "R7 forced zero bits");
        wr(0, 0);

        phase = "R2 R3 R10 fast random";
        fast_mode = 1;
        wr(1, 2); wr(5, 20); wr(6, 30);
        wr(0, 32'h241);
        run(300);

        phase = "R4 clear";
        fast_mode = 2;
        run(2);
        wr(2, 32'h3F);
        rd_now(2, 0, "R4 w1c");

        phase = "R2 slow tick";
        wr(1, 0);
        wr(0, 32'h301);
        run(100);
        phase = "R2 invalid source";
        wr(0, 32'h2C1);
        bus_addr = 9; #1; snap = bus_rdata;
        run(20);
        rd_now(9, snap, "R2 halted counter");

        phase = "R8 enable-mode";
        fast_mode = 0;
        wr(0, 32'h281);
        run(15);
        wr(0, 32'h280);
        wr(0, 32'h283);
        rd_now(9, 0, "R8 restart to zero");
        run(10);
        wr(0, 32'h282);
        bus_addr = 9; #1; snap = bus_rdata;
        wr(0, 32'h281);
        rd_now(9, snap, "R8 value retained");

        phase = "R9 R11 restart mode";
        wr(0, 32'h081);
        run(5);
        wr(4, 9);
        rd_now(9, 0, "R9 cmp1 write restarts");
        run(7);
        wr(5, 3);
        run(40);
        rd_now(2, m_read(2), "R10 R11 status");
        fast_mode = 1;
        run(60);

        phase = "R12 rollover";
        fast_mode = 0;
        wr(2, 32'h3F);
        wr(3, 32'h20);
        wr(0, 32'h240);
        wr(0, 32'h243);
        run(4200);
        bus_addr = 2; #1;
        check("R12 rollover flag only", bus_rdata & 32'h38, 32'h20);
        check("R5 irq high", {31'd0, irq}, 32'd1);
        wr(0, 32'h240);
        check("R5 irq low when disabled", {31'd0, irq}, 32'd0);

        phase = "R7 software reset";
        wr(0, 32'h0000_824B);
        rd_now(0, 32'h240, "R7 ctrl kept bits");
        rd_now(4, 32'hFFF, "R7 cmp1 reset");
        rd_now(2, 0, "R7 status reset");
        rd_now(3, 0, "R7 enable reset");
        rd_now(9, 0, "R7 counter reset");
        run(10);
        finish_up();
    end
endmodule